// File: doc/BRIEF.md
# Five-Channel Buffered Down-Counting PWM Timer

The block holds five down-counters behind a small word-addressed register bus. Four channels drive a PWM pin each. The fifth channel counts and signals expiry but has no compare stage and no pin.

Every channel counts on its own tick. One shared 8-bit prescaler serves channels 0 and 1, and a second serves channels 2, 3 and 4. A per-channel power-of-two divider follows the prescaler.

Software writes a count buffer and, on channels 0 to 3, a compare buffer. These buffers reach the active counter and compare registers only in two ways:
- while the channel's manual-update bit is held set, or
- through auto-reload when an expired counter takes its next tick.

Each channel has a start bit that gates counting. Each channel also gives a one-cycle expiry pulse when its counter reaches zero.

Top module: `pwm_timer5`

## Requirements
- R1: After reset every register reads zero and no expiry pulse appears. Counters stay stopped until software starts them. Because the counter and compare values are both zero, every PWM pin is high after reset.
- R2: Register map by word address:
  - Word 0 is the prescaler. Bits 7:0 serve channels 0 and 1. Bits 15:8 serve channels 2, 3 and 4.
  - Word 1 holds the divider selects. Channel n uses bits 4n+3:4n.
  - Word 2 is the control word. Channel n<4 has start at bit 4n, update at bit 4n+1 and reload at bit 4n+2. Channel 4 has start at bit 16 and update at bit 17.
  - Channel n<4 has its count buffer at word 3+3n, its compare buffer at 4+3n and its live-count view at 5+3n.
  - Channel 4 has its count buffer at word 15 and its live-count view at word 16.
  - All other control bits read zero.
- R3: A running counter steps down by one every (P+1)·2^D clock cycles. P is the group's prescaler value and D is the channel's divider select. With reload on, expiry pulses are (B+1)·(P+1)·2^D cycles apart, where B is the count buffer.
- R4: While a channel's update bit is set, the channel behaves as follows:
  - Its counter takes the count buffer and does not count.
  - Its compare register takes the compare buffer.
  - It gives no expiry pulse in the cycle after the update bit is seen.
- R5: While a channel's start bit is clear, its counter holds its value and it gives no expiry pulse.
- R6: With reload off, a counter that reaches zero stays at zero and gives exactly one pulse.
- R7: A PWM pin is high while the channel's counter is at or below its active compare value. Over one reload period it is high for (C+1)·(P+1)·2^D cycles when C ≤ B.
- R8: The expiry pulse lasts exactly one clock cycle each time the counter steps from one to zero.
- R9: Channel 4 reloads from control bit 19. Bit 18 is reserved: it reads zero and has no effect, so setting it with start makes a single-shot count.
- R10: Writes to the live-count words and to words 17 to 31 change nothing. Words 17 to 31 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 4 | PWM outputs of channels 0 to 3 |
| expire_o | output | 5 | One-cycle expiry pulse per channel |

## Verification
A held manual-update bit and a counter tick that would carry the count from one to zero can fall in the same cycle. The bench provokes this by running channel 1 with a reload value of one on an undivided tick, so an expiry is always at most a cycle away. It then raises the update bit without clearing start. The bench judges the result at the pins: no pulse may appear while the bit is held, and the live-count word must read the buffer value. Pulses must resume once the bit is cleared.

// File: rtl/pwm_timer5.sv
module pwm_timer5 #(
  parameter int CW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [3:0]    pwm_o,
  output logic [4:0]    expire_o
);
  localparam int NCH = 5;
  localparam int NPWM = 4;
  localparam int DW = 15;
  localparam logic [19:0] CTRL_MASK = 20'hB7777;

  logic [15:0] psc;
  logic [19:0] divsel, ctrl;
  logic [NCH-1:0][CW-1:0]  cbuf;
  logic [NPWM-1:0][CW-1:0] mbuf;
  logic [CW-1:0] cnt [NCH];
  logic [CW-1:0] cmp [NPWM];
  logic [7:0]    pcnt [2];
  logic [DW-1:0] dcnt [2];
  logic [1:0]     ptick;
  logic [NCH-1:0] run, upd, rld, tick;

  assign run = {ctrl[16], ctrl[12], ctrl[8], ctrl[4], ctrl[0]};
  assign upd = {ctrl[17], ctrl[13], ctrl[9], ctrl[5], ctrl[1]};
  assign rld = {ctrl[19], ctrl[14], ctrl[10], ctrl[6], ctrl[2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc    <= '0;
      divsel <= '0;
      ctrl   <= '0;
      cbuf   <= '0;
      mbuf   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        AW'(0):  psc     <= bus_wdata[15:0];
        AW'(1):  divsel  <= bus_wdata[19:0];
        AW'(2):  ctrl    <= bus_wdata[19:0] & CTRL_MASK;
        AW'(15): cbuf[4] <= bus_wdata[CW-1:0];
        default: ;
      endcase
      for (int k = 0; k < NPWM; k++) begin
        if (bus_addr == AW'(3 + 3 * k)) cbuf[k] <= bus_wdata[CW-1:0];
        if (bus_addr == AW'(4 + 3 * k)) mbuf[k] <= bus_wdata[CW-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(0):  bus_rdata = {16'b0, psc};
      AW'(1):  bus_rdata = 32'(divsel);
      AW'(2):  bus_rdata = 32'(ctrl);
      AW'(15): bus_rdata = 32'(cbuf[4]);
      AW'(16): bus_rdata = 32'(cnt[4]);
      default: ;
    endcase
    for (int k = 0; k < NPWM; k++) begin
      if (bus_addr == AW'(3 + 3 * k)) bus_rdata = 32'(cbuf[k]);
      if (bus_addr == AW'(4 + 3 * k)) bus_rdata = 32'(mbuf[k]);
      if (bus_addr == AW'(5 + 3 * k)) bus_rdata = 32'(cnt[k]);
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_psc
    logic [7:0] pv;
    assign pv = (g == 0) ? psc[7:0] : psc[15:8];
    assign ptick[g] = (pcnt[g] >= pv);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pcnt[g] <= '0;
        dcnt[g] <= '0;
      end else begin
        pcnt[g] <= ptick[g] ? 8'd0 : pcnt[g] + 8'd1;
        if (ptick[g]) dcnt[g] <= dcnt[g] + DW'(1);
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int G = (i < 2) ? 0 : 1;
    logic [3:0]  dv;
    logic [DW:0] msk;
    logic        exp_q;
    assign dv  = divsel[4*i +: 4];
    assign msk = ((DW+1)'(1) << dv) - (DW+1)'(1);
    assign tick[i] = ptick[G] && ((dcnt[G] & msk[DW-1:0]) == '0);
    assign expire_o[i] = exp_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[i] <= '0;
        exp_q  <= 1'b0;
      end else begin
        exp_q <= 1'b0;
        if (upd[i]) begin
          cnt[i] <= cbuf[i];
        end else if (run[i] && tick[i]) begin
          if (cnt[i] == '0) begin
            if (rld[i]) cnt[i] <= cbuf[i];
          end else begin
            cnt[i] <= cnt[i] - CW'(1);
            exp_q  <= (cnt[i] == CW'(1));
          end
        end
      end
    end

    if (i < NPWM) begin : g_cmp
      always_ff @(posedge clk) begin
        if (!rst_n) cmp[i] <= '0;
        else if (upd[i]) cmp[i] <= mbuf[i];
      end
      assign pwm_o[i] = (cnt[i] <= cmp[i]);
    end
  end
endmodule

module pwm_timer5_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    run,
  input logic [4:0]    upd,
  input logic [4:0]    rld,
  input logic [4:0]    tick,
  input logic [4:0]    expire,
  input logic [CW-1:0] cnt [5]
);
  for (genvar i = 0; i < 5; i++) begin : g_a
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> !expire[i]);
    a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !upd[i]) |=> $stable(cnt[i]));
    a_r6_stop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!rld[i] && !upd[i] && cnt[i] == '0) |=> cnt[i] == '0);
    a_r4_update_blocks_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      upd[i] |=> !expire[i]);
    a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick[i] && !upd[i]) |=> $stable(cnt[i]));
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && !upd[i] && cnt[i] != '0) |=>
        (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) - CW'(1)));
  end
endmodule

bind pwm_timer5 pwm_timer5_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .upd(upd), .rld(rld),
  .tick(tick), .expire(expire_o), .cnt(cnt)
);

// File: tb/sim_pwm_timer5.sv
module sim_pwm_timer5;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_o;
  logic [4:0]  expire_o;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] psc_sh = '0, div_sh = '0, ctrl_sh = '0;

  pwm_timer5 u0 (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .pwm_o, .expire_o);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  task automatic setctrl(input logic [31:0] v);
    ctrl_sh = v;
    wr(2, v);
  endtask

  function automatic int sb(input int ch); return ch < 4 ? 4*ch : 16; endfunction
  function automatic int ub(input int ch); return sb(ch) + 1; endfunction
  function automatic int rb(input int ch); return ch < 4 ? 4*ch + 2 : 19; endfunction
  function automatic int bufa(input int ch); return ch < 4 ? 3 + 3*ch : 15; endfunction
  function automatic int obsa(input int ch); return ch < 4 ? 5 + 3*ch : 16; endfunction
  function automatic int exp_period(input int b, input int p, input int d);
    return (b + 1) * (p + 1) * (1 << d);
  endfunction
  function automatic int exp_high(input int c, input int p, input int d);
    return (c + 1) * (p + 1) * (1 << d);
  endfunction

  task automatic wait_pulse(input int ch, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!expire_o[ch] && n < 5000);
    if (n >= 5000) n = -1;
  endtask

  task automatic count_pulses(input int ch, input int cyc, output int n);
    n = 0;
    for (int j = 0; j < cyc; j++) begin
      @(negedge clk);
      if (expire_o[ch]) n++;
    end
  endtask

  task automatic load(input int ch);
    setctrl(ctrl_sh | (32'd1 << ub(ch)));
    setctrl(ctrl_sh & ~(32'd1 << ub(ch)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int n, m;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 17; a++) begin
      rd(a, v);
      chk(v == 0, "R1 reg zero", v, 0);
    end
    chk(expire_o == 0, "R1 no pulse", expire_o, 0);
    chk(pwm_o == 4'hF, "R1/R7 pwm high", pwm_o, 15);

    // R2 readback
    wr(0, 32'hFFFF_5A3C); rd(0, v); chk(v == 32'h5A3C, "R2 prescaler", v, 32'h5A3C);
    wr(1, 32'hFFFA_BCDE); rd(1, v); chk(v == 32'hABCDE, "R2 divsel", v, 32'hABCDE);
    setctrl(32'hFFFF_FFFF); rd(2, v); chk(v == 32'hB7777, "R2/R9 ctrl mask", v, 32'hB7777);
    setctrl(0);
    wr(4, 32'd9); rd(4, v); chk(v == 9, "R2 compare buffer ch0", v, 9);
    wr(0, 0); psc_sh = 0; wr(1, 0); div_sh = 0;

    // R4 load, R7 level, R6 one-shot
    wr(3, 32'd7); wr(4, 32'd3);
    load(0);
    rd(5, v); chk(v == 7, "R4 update loads count", v, 7);
    chk(pwm_o[0] == 1'b0, "R7 above compare low", pwm_o[0], 0);
    setctrl(32'd1 << sb(0));
    wait_pulse(0, n);
    chk(n > 0, "R6 first pulse", n, 1);
    @(negedge clk);
    chk(expire_o[0] == 1'b0, "R8 pulse one cycle", expire_o[0], 0);
    count_pulses(0, 20, m);
    chk(m == 0, "R6 stops at zero", m, 0);
    rd(5, v); chk(v == 0, "R6 count zero", v, 0);
    chk(pwm_o[0] == 1'b1, "R7 at zero high", pwm_o[0], 1);

    // R10 ignored writes
    wr(5, 32'h55); rd(5, v); chk(v == 0, "R10 observe write ignored", v, 0);
    for (int a = 17; a < 32; a++) wr(a, 32'hFFFF_FFFF);
    rd(3, v); chk(v == 7, "R10 buffer untouched", v, 7);
    rd(2, v); chk(v == ctrl_sh, "R10 ctrl untouched", v, ctrl_sh);
    rd(0, v); chk(v == 0, "R10 psc untouched", v, 0);
    for (int a = 17; a < 32; a++) begin
      rd(a, v); chk(v == 0, "R10 unused reads zero", v, 0);
    end
    setctrl(0);

    // R5 start gating, channel 2
    psc_sh = 32'h0300; wr(0, psc_sh);
    div_sh = 32'h200; wr(1, div_sh);
    wr(bufa(2), 32'd200);
    load(2);
    setctrl((32'd1 << sb(2)) | (32'd1 << rb(2)));
    repeat (40) @(negedge clk);
    setctrl(0);
    rd(obsa(2), v);
    count_pulses(2, 60, m);
    rd(obsa(2), v2);
    chk(v == v2, "R5 holds when stopped", v2, v);
    chk(v != 200, "R5 had counted", v, 199);

    // R4 collision of update and expiry, channel 1
    psc_sh = 0; wr(0, 0); div_sh = 0; wr(1, 0);
    wr(bufa(1), 32'd1);
    load(1);
    setctrl((32'd1 << sb(1)) | (32'd1 << rb(1)));
    count_pulses(1, 10, m);
    chk(m >= 4, "R3 fast reload pulses", m, 5);
    setctrl(ctrl_sh | (32'd1 << ub(1)));
    @(negedge clk);
    count_pulses(1, 10, m);
    chk(m == 0, "R4 no pulse while update held", m, 0);
    rd(obsa(1), v); chk(v == 1, "R4 count held at buffer", v, 1);
    setctrl(ctrl_sh & ~(32'd1 << ub(1)));
    count_pulses(1, 10, m);
    chk(m >= 4, "R4 pulses resume", m, 5);
    setctrl(0);

    // R9 channel 4 reload position
    wr(15, 32'd2);
    load(4);
    setctrl((32'd1 << 16) | (32'd1 << 18));
    rd(2, v); chk(v == (32'd1 << 16), "R9 bit18 reads zero", v, 32'd1 << 16);
    wait_pulse(4, n);
    chk(n > 0, "R9 single pulse", n, 1);
    count_pulses(4, 20, m);
    chk(m == 0, "R9 bit18 gives no reload", m, 0);
    rd(16, v); chk(v == 0, "R9 stopped at zero", v, 0);
    setctrl((32'd1 << 16) | (32'd1 << 19));
    wait_pulse(4, n);
    wait_pulse(4, n);
    chk(n == 3, "R9 reload period", n, 3);
    setctrl(0);

    // R3 / R7 random trials
    for (int t = 0; t < 10; t++) begin
      int ch, p, d, b, c, hi;
      ch = $urandom % 5;
      p = $urandom % 4;
      d = $urandom % 3;
      b = 1 + $urandom % 12;
      c = (t == 0) ? b : $urandom % (b + 1);
      if (ch < 2) psc_sh[7:0] = 8'(p); else psc_sh[15:8] = 8'(p);
      wr(0, psc_sh);
      div_sh[4*ch +: 4] = 4'(d);
      wr(1, div_sh);
      wr(bufa(ch), 32'(b));
      if (ch < 4) wr(4 + 3*ch, 32'(c));
      load(ch);
      setctrl((32'd1 << sb(ch)) | (32'd1 << rb(ch)));
      wait_pulse(ch, n);
      wait_pulse(ch, n);
      wait_pulse(ch, n);
      chk(n == exp_period(b, p, d), "R3 reload period", n, exp_period(b, p, d));
      if (ch < 4) begin
        hi = 0;
        for (int j = 0; j < n; j++) begin
          @(negedge clk);
          if (pwm_o[ch]) hi++;
        end
        chk(hi == exp_high(c, p, d), "R7 pwm high time", hi, exp_high(c, p, d));
      end
      setctrl(0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule